// File: doc/BRIEF.md
# L1 Data Cache Enable and Lock Policy Unit

This block makes the per-access caching decisions for a small set-associative L1 data cache. It holds the tag, valid and replacement state for the cache. For every core load or store it combines three inputs: the cache enable bit, the cache lock bit and the tag lookup. From them it decides whether the cache is consulted at all, whether the access goes to the bus, and which attributes that bus request carries: full-line burst or single beat, cache-inhibited (CI) and write-through (WT). It also decides whether the returned line is written into the cache. Snoop requests from the bus run through the same tag state and may invalidate lines.

Locking freezes allocation without stopping service. Hits are still served, misses still fetch from the bus, but no line is ever installed. Snoops still invalidate, and a slot emptied by a snoop while the lock is held stays unusable until the lock is released. The enable and lock values are captured when a request is accepted and hold for that request until it completes. The data array, the bus protocol timing and address translation are outside the block.

Top module: `cache_policy_unit`

## Requirements
- R1: After reset `req_ready` is 1, `bus_valid`, `rsp_valid` and `fill_valid` are 0, and every line is invalid.
- R2: With the enable bit clear at acceptance, the access neither reads nor changes the tags. It always produces a bus request with `bus_burst`=0, `bus_ci`=1, `bus_wt`=0 and `bus_addr` equal to the full request address. It reports `rsp_hit`=0 and no fill, even when the line is resident.
- R3: With the enable bit clear, a snoop reports `snp_hit`=0 and leaves every line untouched, so a resident line still hits once the cache is enabled again.
- R4: An enabled access that hits, whether locked or not, issues no bus request. `rsp_valid`=1 and `rsp_hit`=1 appear in the cycle after acceptance.
- R5: An enabled, unlocked miss (load or store) issues a burst with `bus_ci`=0, `bus_wt`=0 and the line-aligned address, which is the address with its low log2(LINE_BYTES)=5 bits cleared. The cycle after the bus handshake carries `fill_valid`=1 with the set (address bits [6:5] by default), the tag (the bits above) and the target way.
- R6: The fill targets the least recently used way of the set. Both hits and fills count as uses. After reset, way 1 is the least recently used way of every set.
- R7: An enabled, locked load miss issues a burst with `bus_ci`=0 and `bus_wt`=0 to the line-aligned address, and never asserts `fill_valid`. A repeat of the load misses again.
- R8: An enabled, locked store miss issues a single-beat request with `bus_wt`=1, `bus_ci`=0 and the full address, and no fill.
- R9: With the cache enabled, a snoop whose line is resident reports `snp_hit`=1 in the same cycle and invalidates the line whether or not the cache is locked.
- R10: A way emptied by a snoop while the lock is set cannot be refilled until the lock bit is 0. A fill aimed at such a way by a request already in flight is dropped, with `fill_valid`=0 and the tags unchanged. After unlock the way fills normally.
- R11: The lock bit counts only at acceptance. Raising it while a request waits for the bus changes neither that request's attributes nor its fill.
- R12: While `bus_valid`=1 and `bus_ready`=0, the request stays asserted and its address and attributes stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Cache enable bit |
| cfg_lock | input | 1 | Cache lock bit |
| req_valid | input | 1 | Core access request |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the access |
| rsp_valid | output | 1 | Access completed (one cycle) |
| rsp_hit | output | 1 | Access was served by the cache |
| snp_valid | input | 1 | Snoop invalidate request (one cycle) |
| snp_line | input | ADDR_W-5 | Line address of the snoop |
| snp_hit | output | 1 | Snoop found a resident line |
| fill_valid | output | 1 | Write the returned line into the cache |
| fill_set | output | log2(SETS) | Set written by the fill |
| fill_way | output | log2(WAYS) | Way written by the fill |
| fill_tag | output | ADDR_W-5-log2(SETS) | Tag written by the fill |
| bus_valid | output | 1 | Bus request descriptor valid |
| bus_ready | input | 1 | Bus accepts the descriptor |
| bus_addr | output | ADDR_W | Request address (line-aligned for bursts) |
| bus_burst | output | 1 | 1 = 32-byte line burst, 0 = single beat |
| bus_ci | output | 1 | Cache-inhibited attribute |
| bus_wt | output | 1 | Write-through attribute |

## Verification
The hardest situation to reach is a fill that is dropped. It requires a request that is accepted while unlocked and still waiting on the bus, followed by the lock rising, and then a snoop that empties exactly the way chosen as the victim. The bench first arranges the replacement order so that the victim way holds a known line. It then holds `bus_ready` low on an unlocked store miss, raises the lock, snoops that line, and only then releases the bus. After the directed cases, a long pseudo-random sweep over enable, lock, load/store, snoops and bus stalls on a four-set, two-way configuration is compared against an arithmetic model of tags and replacement order.

// File: rtl/clp_pkg.sv
package clp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_RSP  = 2'd2
    } clp_state_e;

    // Policy decision for one accepted access
    typedef struct packed {
        logic need_bus;
        logic burst;
        logic ci;
        logic wt;
        logic alloc;
    } clp_action_t;

endpackage

// File: rtl/clp_policy.sv
module clp_policy
    import clp_pkg::*;
(
    input  logic        en,
    input  logic        lock,
    input  logic        wr,
    input  logic        hit,
    output clp_action_t act
);

    always_comb begin
        act = '0;
        if (!en) begin
            // cache bypassed: single beat, inhibited, tags ignored
            act.need_bus = 1'b1;
            act.ci       = 1'b1;
        end else if (hit) begin
            // served locally, locked or not
            act = '0;
        end else if (!lock) begin
            act.need_bus = 1'b1;
            act.burst    = 1'b1;
            act.alloc    = 1'b1;
        end else if (wr) begin
            act.need_bus = 1'b1;
            act.wt       = 1'b1;
        end else begin
            act.need_bus = 1'b1;
            act.burst    = 1'b1;
        end
    end

endmodule

// File: rtl/clp_tags.sv
module clp_tags #(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int TAG_W = 9,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock,
    // lookup
    input  logic             lk_en,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [WAY_W-1:0] lk_way,
    output logic [WAY_W-1:0] vic_way,
    // recency update
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    // line install
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    // snoop
    input  logic             snp_en,
    input  logic [SET_W-1:0] snp_set,
    input  logic [TAG_W-1:0] snp_tag,
    output logic             snp_hit,
    // blocked query
    input  logic [SET_W-1:0] qry_set,
    input  logic [WAY_W-1:0] qry_way,
    output logic             qry_blocked
);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             vld;
        logic [SETS-1:0][WAYS-1:0]             blk;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][WAYS-1:0][WAY_W-1:0]  age;
    } store_t;

    store_t st_d, st_q;
    logic [WAYS-1:0] hit_vec, snp_vec;

    function automatic store_t store_reset();
        store_t s;
        s = '0;
        for (int si = 0; si < SETS; si++)
            for (int wi = 0; wi < WAYS; wi++)
                s.age[si][wi] = WAY_W'(wi);
        return s;
    endfunction

    // way compare
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = st_q.vld[lk_set][w] && (st_q.tag[lk_set][w] == lk_tag);
        assign snp_vec[w] = st_q.vld[snp_set][w] && (st_q.tag[snp_set][w] == snp_tag);
    end

    always_comb begin
        lk_way  = '0;
        vic_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) lk_way = WAY_W'(w);
            if (st_q.age[lk_set][w] == WAY_W'(WAYS - 1)) vic_way = WAY_W'(w);
        end
    end

    assign lk_hit      = lk_en && (|hit_vec);
    assign snp_hit     = snp_en && (|snp_vec);
    assign qry_blocked = st_q.blk[qry_set][qry_way];

    always_comb begin
        st_d = st_q;
        if (!lock) st_d.blk = '0;
        if (snp_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (snp_vec[w]) begin
                    st_d.vld[snp_set][w] = 1'b0;
                    if (lock) st_d.blk[snp_set][w] = 1'b1;
                end
            end
        end
        if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    st_d.age[touch_set][w] = '0;
                else if (st_q.age[touch_set][w] < st_q.age[touch_set][touch_way])
                    st_d.age[touch_set][w] = st_q.age[touch_set][w] + 1'b1;
            end
        end
        if (fill_en) begin
            st_d.vld[fill_set][fill_way] = 1'b1;
            st_d.tag[fill_set][fill_way] = fill_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= store_reset();
        else        st_q <= st_d;
    end

    // a tag appears at most once per set
    assert_single_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // no install into a way emptied by a snoop under lock
    assert_fill_not_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> !st_q.blk[fill_set][fill_way]);

    // a snoop invalidation under lock leaves the way blocked next cycle
    assert_snoop_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_hit && lock && !fill_en) |=> (lock |-> st_q.blk[$past(snp_set)] != '0));

endmodule

// File: rtl/cache_policy_unit.sv
module cache_policy_unit
    import clp_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 32,
    parameter int SETS       = 4,
    parameter int WAYS       = 2,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int LINE_W = ADDR_W - OFF_W,
    localparam int TAG_W  = LINE_W - SET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_lock,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    input  logic              snp_valid,
    input  logic [LINE_W-1:0] snp_line,
    output logic              snp_hit,
    output logic              fill_valid,
    output logic [SET_W-1:0]  fill_set,
    output logic [WAY_W-1:0]  fill_way,
    output logic [TAG_W-1:0]  fill_tag,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_burst,
    output logic              bus_ci,
    output logic              bus_wt
);

    typedef struct packed {
        clp_state_e        state;
        logic              en;
        logic              lock;
        logic              wr;
        logic              hit;
        logic [ADDR_W-1:0] addr;
        logic [WAY_W-1:0]  way;
        clp_action_t       act;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             accept;
    logic             lk_hit, qry_blocked;
    logic [WAY_W-1:0] lk_way, vic_way;
    clp_action_t      act_new;
    logic             touch_en;
    logic [SET_W-1:0] touch_set;
    logic [WAY_W-1:0] touch_way;

    wire [SET_W-1:0] req_set = req_addr[OFF_W +: SET_W];
    wire [TAG_W-1:0] req_tag = req_addr[ADDR_W-1 -: TAG_W];
    wire [SET_W-1:0] q_set   = ctl_q.addr[OFF_W +: SET_W];
    wire [TAG_W-1:0] q_tag   = ctl_q.addr[ADDR_W-1 -: TAG_W];

    assign accept = req_valid && (ctl_q.state == ST_IDLE);

    clp_policy u_policy (
        .en   (cfg_enable),
        .lock (cfg_lock),
        .wr   (req_write),
        .hit  (lk_hit),
        .act  (act_new)
    );

    clp_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock        (cfg_lock),
        .lk_en       (cfg_enable),
        .lk_set      (req_set),
        .lk_tag      (req_tag),
        .lk_hit      (lk_hit),
        .lk_way      (lk_way),
        .vic_way     (vic_way),
        .touch_en    (touch_en),
        .touch_set   (touch_set),
        .touch_way   (touch_way),
        .fill_en     (fill_valid),
        .fill_set    (q_set),
        .fill_way    (ctl_q.way),
        .fill_tag    (q_tag),
        .snp_en      (snp_valid && cfg_enable),
        .snp_set     (snp_line[SET_W-1:0]),
        .snp_tag     (snp_line[LINE_W-1 -: TAG_W]),
        .snp_hit     (snp_hit),
        .qry_set     (q_set),
        .qry_way     (ctl_q.way),
        .qry_blocked (qry_blocked)
    );

    // next-state
    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_IDLE: if (accept) begin
                ctl_d.en    = cfg_enable;
                ctl_d.lock  = cfg_lock;
                ctl_d.wr    = req_write;
                ctl_d.hit   = lk_hit;
                ctl_d.addr  = req_addr;
                ctl_d.way   = lk_hit ? lk_way : vic_way;
                ctl_d.act   = act_new;
                ctl_d.state = act_new.need_bus ? ST_BUS : ST_RSP;
            end
            ST_BUS:  if (bus_ready) ctl_d.state = ST_RSP;
            ST_RSP:  ctl_d.state = ST_IDLE;
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // outputs
    assign req_ready  = (ctl_q.state == ST_IDLE);
    assign rsp_valid  = (ctl_q.state == ST_RSP);
    assign rsp_hit    = rsp_valid && ctl_q.hit;
    assign bus_valid  = (ctl_q.state == ST_BUS);
    assign bus_burst  = ctl_q.act.burst;
    assign bus_ci     = ctl_q.act.ci;
    assign bus_wt     = ctl_q.act.wt;
    assign bus_addr   = ctl_q.act.burst ? {ctl_q.addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                                        : ctl_q.addr;
    assign fill_valid = rsp_valid && ctl_q.act.alloc && !qry_blocked;
    assign fill_set   = q_set;
    assign fill_way   = ctl_q.way;
    assign fill_tag   = q_tag;

    assign touch_en  = (accept && lk_hit) || fill_valid;
    assign touch_set = accept ? req_set : q_set;
    assign touch_way = accept ? lk_way  : ctl_q.way;

    // assertions
    assert_bypass_attrs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !ctl_q.en) |-> (bus_ci && !bus_burst && !bus_wt && bus_addr == ctl_q.addr));

    assert_bypass_no_snoop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !cfg_enable) |-> !snp_hit);

    assert_hit_no_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> $past(req_valid && req_ready));

    assert_locked_no_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (ctl_q.en && !ctl_q.lock));

    assert_locked_store_wt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && ctl_q.en && ctl_q.lock && ctl_q.wr) |-> (bus_wt && !bus_burst && !bus_ci));

    assert_lock_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> $stable(ctl_q.lock));

    assert_bus_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_burst)
                                       && $stable(bus_ci) && $stable(bus_wt)));

endmodule

// File: tb/sim_cache_policy_unit.sv
module sim_cache_policy_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_enable, cfg_lock;
    logic        req_valid, req_ready, req_write;
    logic [15:0] req_addr;
    logic        rsp_valid, rsp_hit;
    logic        snp_valid;
    logic [10:0] snp_line;
    logic        snp_hit;
    logic        fill_valid;
    logic [1:0]  fill_set;
    logic        fill_way;
    logic [8:0]  fill_tag;
    logic        bus_valid, bus_ready;
    logic [15:0] bus_addr;
    logic        bus_burst, bus_ci, bus_wt;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    cache_policy_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_lock(cfg_lock),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .snp_valid(snp_valid), .snp_line(snp_line), .snp_hit(snp_hit),
        .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
        .bus_burst(bus_burst), .bus_ci(bus_ci), .bus_wt(bus_wt)
    );

    // observed results of the last access
    bit          o_bus, o_burst, o_ci, o_wt, o_fill, o_fway, o_hit, o_moved;
    logic [15:0] o_baddr;
    logic [1:0]  o_fset;
    logic [8:0]  o_ftag;

    // reference model state (4 sets x 2 ways)
    bit         m_vld [4][2];
    logic [8:0] m_tag [4][2];
    bit         m_lru [4];

    task automatic chk(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < 4; s++) begin
            m_lru[s] = 1'b1;
            for (int w = 0; w < 2; w++) begin m_vld[s][w] = 1'b0; m_tag[s][w] = '0; end
        end
    endtask

    task automatic start_req(input bit en, input bit lk, input bit wr, input logic [15:0] a);
        cfg_enable = en; cfg_lock = lk;
        req_valid = 1'b1; req_write = wr; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish(input int hold);
        int waited = 0;
        bit done = 1'b0;
        o_bus = 0; o_fill = 0; o_hit = 0; o_moved = 0;
        while (!done) begin
            if (bus_valid) begin
                if (!o_bus) begin
                    o_bus = 1; o_burst = bus_burst; o_ci = bus_ci; o_wt = bus_wt; o_baddr = bus_addr;
                end else if (bus_addr !== o_baddr || bus_burst !== o_burst ||
                             bus_ci !== o_ci || bus_wt !== o_wt) begin
                    o_moved = 1;
                end
                if (waited >= hold) bus_ready = 1'b1;
                waited++;
            end else if (rsp_valid) begin
                o_hit = rsp_hit; o_fill = fill_valid;
                o_fway = fill_way; o_fset = fill_set; o_ftag = fill_tag;
                done = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
            bus_ready = 1'b0;
        end
    endtask

    task automatic access(input bit en, input bit lk, input bit wr, input logic [15:0] a,
                          input int hold);
        start_req(en, lk, wr, a);
        finish(hold);
    endtask

    task automatic snoop(input bit en, input bit lk, input logic [15:0] a, output bit hit);
        cfg_enable = en; cfg_lock = lk;
        snp_valid = 1'b1; snp_line = a[15:5];
        #1 hit = snp_hit;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    // model-driven access with full comparison
    task automatic model_access(input bit en, input bit lk, input bit wr, input logic [15:0] a,
                                input int hold);
        int s = a[6:5];
        logic [8:0] t = a[15:7];
        bit h = 0, hw = 0;
        string r;
        if (en) for (int w = 0; w < 2; w++)
            if (m_vld[s][w] && m_tag[s][w] == t) begin h = 1; hw = w[0]; end
        access(en, lk, wr, a, hold);
        r = !en ? "R2" : h ? "R4" : !lk ? "R5" : wr ? "R8" : "R7";
        chk(r, "rsp_hit", o_hit, h);
        chk(r, "bus request", o_bus, !h);
        chk("R12", "descriptor held", o_moved, 0);
        if (!en) begin
            chk(r, "ci", o_ci, 1); chk(r, "burst", o_burst, 0);
            chk(r, "wt", o_wt, 0); chk(r, "addr", o_baddr, a);
        end else if (!h) begin
            chk(r, "ci", o_ci, 0);
            chk(r, "burst", o_burst, !(lk && wr));
            chk(r, "wt", o_wt, lk && wr);
            chk(r, "addr", o_baddr, (lk && wr) ? a : {a[15:5], 5'b0});
        end
        chk(r, "fill_valid", o_fill, en && !h && !lk);
        if (h) m_lru[s] = !hw;
        else if (en && !lk) begin
            chk("R6", "fill way", o_fway, m_lru[s]);
            chk("R5", "fill set", o_fset, s[1:0]);
            chk("R5", "fill tag", o_ftag, t);
            m_vld[s][m_lru[s]] = 1; m_tag[s][m_lru[s]] = t;
            m_lru[s] = !m_lru[s];
        end
    endtask

    task automatic model_snoop(input bit en, input bit lk, input logic [15:0] a);
        int s = a[6:5];
        bit h = 0, got;
        if (en) for (int w = 0; w < 2; w++)
            if (m_vld[s][w] && m_tag[s][w] == a[15:7]) begin h = 1; m_vld[s][w] = 0; end
        snoop(en, lk, a, got);
        chk(en ? "R9" : "R3", "snp_hit", got, h);
    endtask

    function automatic logic [31:0] xs(input logic [31:0] v);
        logic [31:0] x = v;
        x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
        return x;
    endfunction

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit sh;
        logic [31:0] r;
        rst_n = 1'b0; cfg_enable = 0; cfg_lock = 0;
        req_valid = 0; req_write = 0; req_addr = '0;
        snp_valid = 0; snp_line = '0; bus_ready = 0;
        do_reset();

        // R1: idle state after reset
        chk("R1", "req_ready", req_ready, 1);
        chk("R1", "bus_valid", bus_valid, 0);
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "fill_valid", fill_valid, 0);
        access(1, 0, 0, 16'h0080, 0);
        chk("R1", "first access misses", o_hit, 0);
        chk("R6", "reset victim is way 1", o_fway, 1);

        // R2: bypass even though line is resident
        access(0, 0, 0, 16'h0087, 0);
        chk("R2", "ci", o_ci, 1); chk("R2", "hit", o_hit, 0);
        chk("R2", "addr", o_baddr, 16'h0087); chk("R2", "fill", o_fill, 0);

        // R3: snoop ignored while disabled, line still hits afterwards
        snoop(0, 0, 16'h0080, sh);
        chk("R3", "snp_hit while disabled", sh, 0);
        access(1, 0, 0, 16'h0080, 0);
        chk("R3", "line still resident", o_hit, 1);
        chk("R4", "hit issues no bus", o_bus, 0);

        // R4 locked hit, then R9 snoop under lock, R7 locked load miss
        access(1, 1, 0, 16'h0090, 0);
        chk("R4", "locked hit", o_hit, 1);
        snoop(1, 1, 16'h0080, sh);
        chk("R9", "snp_hit under lock", sh, 1);
        access(1, 1, 0, 16'h0080, 0);
        chk("R9", "invalidated line misses", o_hit, 0);
        chk("R7", "locked load burst", o_burst, 1);
        chk("R7", "locked load no fill", o_fill, 0);
        access(1, 1, 0, 16'h0080, 1);
        chk("R7", "repeat load still misses", o_hit, 0);

        // R11: lock raised while an unlocked store miss waits
        do_reset();
        start_req(1, 0, 1, 16'h0123);
        cfg_lock = 1'b1;
        finish(3);
        chk("R11", "burst kept", o_burst, 1);
        chk("R11", "no write-through", o_wt, 0);
        chk("R11", "fill kept", o_fill, 1);
        cfg_lock = 1'b0;

        // R10: snoop empties the victim way while a fill is in flight
        do_reset();
        access(1, 0, 0, 16'h0080, 0);   // A -> way1
        access(1, 0, 0, 16'h0100, 0);   // B -> way0
        chk("R6", "second line to way 0", o_fway, 0);
        access(1, 0, 0, 16'h0080, 0);   // A hit, way0 now LRU
        chk("R6", "refresh hit", o_hit, 1);
        start_req(1, 0, 1, 16'h0184);   // C store miss, victim way0
        cfg_lock = 1'b1;
        snoop(1, 1, 16'h0100, sh);
        chk("R10", "snoop hits victim", sh, 1);
        finish(1);
        chk("R10", "fill dropped", o_fill, 0);
        chk("R11", "store still burst", o_burst, 1);
        access(1, 1, 0, 16'h0180, 0);
        chk("R10", "C not installed", o_hit, 0);
        access(1, 1, 0, 16'h0100, 0);
        chk("R10", "B stays empty", o_hit, 0);
        access(1, 0, 0, 16'h0180, 0);
        chk("R10", "refill after unlock", o_fill, 1);
        chk("R10", "refill way", o_fway, 0);
        access(1, 0, 0, 16'h0180, 0);
        chk("R10", "refilled line hits", o_hit, 1);

        // R8 directed: locked store miss
        access(1, 1, 1, 16'h0e4b, 2);
        chk("R8", "wt", o_wt, 1); chk("R8", "single", o_burst, 0);
        chk("R8", "addr", o_baddr, 16'h0e4b); chk("R8", "ci", o_ci, 0);

        // sweep against the model
        do_reset();
        r = 32'h1d2c3b4a;
        for (int i = 0; i < 1500; i++) begin
            logic [15:0] a;
            bit en, lk, wr;
            r = xs(r);
            a  = {5'b0, 2'b0, r[3:2], r[1:0], r[8:4]};
            en = (r[11:10] != 2'b00);
            lk = r[12] & r[13];
            wr = r[14];
            if (r[15] & r[16]) model_snoop(r[17] | r[18], lk, {5'b0, 2'b0, r[20:19], r[22:21], 5'b0});
            model_access(en, lk, wr, a, int'(r[24:23]) % 3);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule